// File: doc/BRIEF.md
# Status Word and Exception Entry Controller

This block owns the 32-bit processor status word of a CPU core, together with one pair of banked registers for each exception mode. Each pair is a saved copy of the status word and a return address. Every cycle it arbitrates among seven exception sources: soft reset, undefined instruction, supervisor call, prefetch abort, data abort, normal interrupt and fast interrupt. When one is taken, it stores the running PC and status in the target mode's bank. It then switches mode, applies the interrupt masks, forces the 32-bit instruction set and emits a one-cycle PC load with the vector.

The fetch unit consumes `pc_load`/`pc_vec`. The decoder reads the mode, instruction-set and mask outputs. The datapath drives the flag strobe and the software status writes. A return request restores the status word from the current mode's bank and reloads the PC from the banked link value minus a small adjustment.

Top module: `psw_exc_ctrl`

## Requirements
- R1: After synchronous reset the status word reads 0x000000D3: supervisor mode 0x13, both interrupt disables set, state bit 0, flags 0. `pc_load` is low.
- R2: When several exception requests are active together, exactly one is served. The winner is the first available in this order: soft reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, supervisor call.
- R3: A taken exception raises `pc_load` in the next cycle only, with `pc_vec` = 4 × type. The types are reset 0, undefined 1, supervisor call 2, prefetch abort 3, data abort 4, normal interrupt 6 and fast interrupt 7. The mode field becomes 0x13 for reset and supervisor call, 0x1B for undefined, 0x17 for both aborts, 0x12 for the normal interrupt and 0x11 for the fast interrupt.
- R4: On entry, bit 7 (normal-interrupt disable) is set. Bit 6 (fast-interrupt disable) is set as well for reset and fast interrupt, and is otherwise unchanged. Bit 5 (state) is cleared. Flags and reserved bits are unchanged.
- R5: A normal interrupt request is ignored while bit 7 is set. A fast interrupt request is ignored while bit 6 is set.
- R6: On entry the old status word and `cur_pc` are stored in the bank of the target mode. A return in modes 0x11, 0x12, 0x13, 0x17 and 0x1B reloads the status word from that mode's bank. It also pulses `pc_load` with `pc_vec` = banked PC − `ret_adj`. In user mode 0x10 and system mode 0x1F a return is ignored.
- R7: `flag_we` copies `flag_nzcv` into bits 31:28 in N, Z, C, V order and changes no other bit.
- R8: A software write with `sw_sel[1]` set replaces bits 31:28. A write with `sw_sel[0]` set replaces bits 7:0. Bits 27:8 are never changed by any write.
- R9: In user mode 0x10 the control part (bits 7:0) of a software write is ignored. The flag part still applies.
- R10: A control write whose mode field is not one of 0x10, 0x11, 0x12, 0x13, 0x17, 0x1B or 0x1F leaves the mode unchanged. Bits 7:5 are still written.
- R11: Within one cycle, exception entry has precedence over a return. A return has precedence over a software write, and a software write has precedence over the flag strobe. An ignored return does not block the lower-priority actions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_reset | input | 1 | Soft reset exception request |
| req_undef | input | 1 | Undefined instruction request |
| req_svc | input | 1 | Supervisor call request |
| req_pabort | input | 1 | Prefetch abort request |
| req_dabort | input | 1 | Data abort request |
| req_int | input | 1 | Normal interrupt request |
| req_fint | input | 1 | Fast interrupt request |
| cur_pc | input | PC_W | PC to bank on entry |
| flag_we | input | 1 | Flag update strobe |
| flag_nzcv | input | 4 | New flags N, Z, C, V |
| sw_we | input | 1 | Software status write |
| sw_sel | input | 2 | Field select: bit 1 flags, bit 0 control |
| sw_data | input | 32 | Software write value |
| ret_req | input | 1 | Return from exception |
| ret_adj | input | 4 | Amount subtracted from banked PC on return |
| pc_load | output | 1 | One-cycle PC redirect |
| pc_vec | output | PC_W | Redirect target |
| cur_mode | output | 5 | Current mode field |
| half_isa | output | 1 | State bit: 16-bit instruction set |
| int_mask | output | 1 | Normal interrupt disabled |
| fint_mask | output | 1 | Fast interrupt disabled |
| psw_out | output | 32 | Full status word |

## Verification
Every combination of the seven requests is swept under all four mask settings, each followed by a return. An arbiter with a wrong ordering would send the wrong vector, and a mask ignored would enter an interrupt that should have been held off. A wrong bank index would restore another mode's status word or PC on return. A run of mixed random traffic puts entry, return, software write and flag strobe in the same cycle, which exposes any swap in precedence. Directed writes with all ones, with invalid mode codes and from user mode would show reserved bits being altered, an illegal mode being stored, or control bits escaping the privilege check.

// File: rtl/psw_pkg.sv
`timescale 1ns/1ps
package psw_pkg;

    localparam int PSW_W  = 32;
    localparam int NBANK  = 5;
    localparam int BIDX_W = $clog2(NBANK);
    localparam int EXC_N  = 8;
    localparam int EXC_W  = $clog2(EXC_N);

    localparam logic [PSW_W-1:0] RSV_MASK  = 32'h0FFF_FF00;
    localparam logic [PSW_W-1:0] FLAG_MASK = 32'hF000_0000;
    localparam logic [PSW_W-1:0] CTL_MASK  = 32'h0000_00E0;
    localparam logic [PSW_W-1:0] MODE_MASK = 32'h0000_001F;
    localparam logic [PSW_W-1:0] PSW_RST   = 32'h0000_00D3;

    typedef enum logic [4:0] {
        M_USR = 5'h10,
        M_FST = 5'h11,
        M_INT = 5'h12,
        M_SUP = 5'h13,
        M_ABT = 5'h17,
        M_UND = 5'h1B,
        M_SYS = 5'h1F
    } mode_e;

    // exception type; vector = type * 4, so the numbering is behaviour
    typedef enum logic [EXC_W-1:0] {
        EX_RST  = 3'd0,
        EX_UND  = 3'd1,
        EX_SVC  = 3'd2,
        EX_PABT = 3'd3,
        EX_DABT = 3'd4,
        EX_RSV  = 3'd5,
        EX_INT  = 3'd6,
        EX_FINT = 3'd7
    } exc_e;

    typedef struct packed {
        logic [3:0]  nzcv;
        logic [19:0] rsv;
        logic        idis;
        logic        fdis;
        logic        half;
        logic [4:0]  mode;
    } psw_t;

    typedef struct packed {
        logic              ok;
        logic [BIDX_W-1:0] idx;
    } bank_sel_t;

    function automatic logic mode_valid(input logic [4:0] m);
        case (m)
            M_USR, M_FST, M_INT, M_SUP, M_ABT, M_UND, M_SYS: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bank_sel_t mode_bank(input logic [4:0] m);
        bank_sel_t b;
        b.ok = 1'b1;
        case (m)
            M_FST:   b.idx = BIDX_W'(0);
            M_INT:   b.idx = BIDX_W'(1);
            M_SUP:   b.idx = BIDX_W'(2);
            M_ABT:   b.idx = BIDX_W'(3);
            M_UND:   b.idx = BIDX_W'(4);
            default: begin b.ok = 1'b0; b.idx = '0; end
        endcase
        return b;
    endfunction

    function automatic logic [4:0] exc_mode(input logic [EXC_W-1:0] t);
        case (t)
            EX_UND:           return M_UND;
            EX_PABT, EX_DABT: return M_ABT;
            EX_INT:           return M_INT;
            EX_FINT:          return M_FST;
            default:          return M_SUP;
        endcase
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
`timescale 1ns/1ps
module exc_arbiter
    import psw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [EXC_N-1:0] req,
    input  logic             idis,
    input  logic             fdis,
    output logic             take,
    output logic [EXC_W-1:0] sel
);
    logic int_ok, fint_ok;

    assign int_ok  = req[EX_INT]  && !idis;
    assign fint_ok = req[EX_FINT] && !fdis;

    always_comb begin
        take = 1'b1;
        sel  = EX_RST;
        if (req[EX_RST])       sel = EX_RST;
        else if (req[EX_DABT]) sel = EX_DABT;
        else if (fint_ok)      sel = EX_FINT;
        else if (int_ok)       sel = EX_INT;
        else if (req[EX_PABT]) sel = EX_PABT;
        else if (req[EX_UND])  sel = EX_UND;
        else if (req[EX_SVC])  sel = EX_SVC;
        else if (req[EX_RSV])  sel = EX_RSV;
        else                   take = 1'b0;
    end

    // R5
    int_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (take && sel == EX_INT) |-> !idis);
    // R5
    fint_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (take && sel == EX_FINT) |-> !fdis);
    // R2
    reset_wins_chk: assert property (@(posedge clk) disable iff (rst)
        req[EX_RST] |-> (take && sel == EX_RST));

endmodule

// File: rtl/exc_bank.sv
`timescale 1ns/1ps
module exc_bank
    import psw_pkg::*;
#(
    parameter int LW = 32,
    parameter int SW = PSW_W,
    parameter int NB = NBANK,
    parameter int IW = BIDX_W,
    parameter logic [SW-1:0] SAV_RST = PSW_RST
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [LW-1:0] wlink,
    input  logic [SW-1:0] wsav,
    input  logic [IW-1:0] ridx,
    output logic [LW-1:0] rlink,
    output logic [SW-1:0] rsav
);
    logic [LW-1:0] link_q [NB];
    logic [SW-1:0] sav_q  [NB];

    for (genvar g = 0; g < NB; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                link_q[g] <= '0;
                sav_q[g]  <= SAV_RST;
            end else if (we && widx == IW'(g)) begin
                link_q[g] <= wlink;
                sav_q[g]  <= wsav;
            end
        end
    end

    always_comb begin
        rlink = '0;
        rsav  = SAV_RST;
        for (int i = 0; i < NB; i++) begin
            if (ridx == IW'(i)) begin
                rlink = link_q[i];
                rsav  = sav_q[i];
            end
        end
    end

endmodule

// File: rtl/psw_next.sv
`timescale 1ns/1ps
module psw_next
    import psw_pkg::*;
(
    input  psw_t             cur,
    input  logic             flag_we,
    input  logic [3:0]       flag_nzcv,
    input  logic             sw_we,
    input  logic [1:0]       sw_sel,
    input  logic [PSW_W-1:0] sw_data,
    output psw_t             nxt
);
    logic             priv;
    logic [PSW_W-1:0] wmask;

    assign priv = (cur.mode != M_USR);

    always_comb begin
        wmask = '0;
        if (sw_sel[1])
            wmask = wmask | FLAG_MASK;
        if (sw_sel[0] && priv) begin
            wmask = wmask | CTL_MASK;
            if (mode_valid(sw_data[4:0]))
                wmask = wmask | MODE_MASK;
        end
        wmask = wmask & ~RSV_MASK;
    end

    always_comb begin
        nxt = cur;
        if (sw_we)
            nxt = psw_t'((PSW_W'(cur) & ~wmask) | (sw_data & wmask));
        else if (flag_we)
            nxt.nzcv = flag_nzcv;
    end

endmodule

// File: rtl/psw_exc_ctrl.sv
`timescale 1ns/1ps
module psw_exc_ctrl
    import psw_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_reset,
    input  logic             req_undef,
    input  logic             req_svc,
    input  logic             req_pabort,
    input  logic             req_dabort,
    input  logic             req_int,
    input  logic             req_fint,
    input  logic [PC_W-1:0]  cur_pc,
    input  logic             flag_we,
    input  logic [3:0]       flag_nzcv,
    input  logic             sw_we,
    input  logic [1:0]       sw_sel,
    input  logic [PSW_W-1:0] sw_data,
    input  logic             ret_req,
    input  logic [3:0]       ret_adj,
    output logic             pc_load,
    output logic [PC_W-1:0]  pc_vec,
    output logic [4:0]       cur_mode,
    output logic             half_isa,
    output logic             int_mask,
    output logic             fint_mask,
    output logic [PSW_W-1:0] psw_out
);
    psw_t             psw_q, psw_upd, psw_ent, rsav_w;
    logic [EXC_N-1:0] req;
    logic             take, ret_go;
    logic [EXC_W-1:0] sel;
    logic [4:0]       tgt_mode;
    bank_sel_t        tgt_bank, cur_bank;
    logic [PC_W-1:0]  rlink;
    logic [PSW_W-1:0] rsav;

    always_comb begin
        req           = '0;
        req[EX_RST]   = req_reset;
        req[EX_UND]   = req_undef;
        req[EX_SVC]   = req_svc;
        req[EX_PABT]  = req_pabort;
        req[EX_DABT]  = req_dabort;
        req[EX_INT]   = req_int;
        req[EX_FINT]  = req_fint;
    end

    exc_arbiter u_arb (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .idis (psw_q.idis),
        .fdis (psw_q.fdis),
        .take (take),
        .sel  (sel)
    );

    assign tgt_mode = exc_mode(sel);
    assign tgt_bank = mode_bank(tgt_mode);
    assign cur_bank = mode_bank(psw_q.mode);
    assign ret_go   = ret_req && cur_bank.ok && !take;

    exc_bank #(
        .LW (PC_W),
        .SW (PSW_W)
    ) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (take),
        .widx  (tgt_bank.idx),
        .wlink (cur_pc),
        .wsav  (PSW_W'(psw_q)),
        .ridx  (cur_bank.idx),
        .rlink (rlink),
        .rsav  (rsav)
    );
    assign rsav_w = psw_t'(rsav);

    psw_next u_next (
        .cur       (psw_q),
        .flag_we   (flag_we),
        .flag_nzcv (flag_nzcv),
        .sw_we     (sw_we),
        .sw_sel    (sw_sel),
        .sw_data   (sw_data),
        .nxt       (psw_upd)
    );

    always_comb begin
        psw_ent      = psw_q;
        psw_ent.mode = tgt_mode;
        psw_ent.idis = 1'b1;
        psw_ent.half = 1'b0;
        if (sel == EX_RST || sel == EX_FINT)
            psw_ent.fdis = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            psw_q   <= psw_t'(PSW_RST);
            pc_load <= 1'b0;
            pc_vec  <= '0;
        end else if (take) begin
            psw_q   <= psw_ent;
            pc_load <= 1'b1;
            pc_vec  <= PC_W'({sel, 2'b00});
        end else if (ret_go) begin
            psw_q   <= rsav_w;
            pc_load <= 1'b1;
            pc_vec  <= rlink - PC_W'(ret_adj);
        end else begin
            psw_q   <= psw_upd;
            pc_load <= 1'b0;
        end
    end

    assign cur_mode  = psw_q.mode;
    assign half_isa  = psw_q.half;
    assign int_mask  = psw_q.idis;
    assign fint_mask = psw_q.fdis;
    assign psw_out   = PSW_W'(psw_q);

    // R4
    entry_state_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (pc_load && psw_q.idis && !psw_q.half));
    // R8
    rsv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (psw_q.rsv == $past(psw_q.rsv)));
    // R9
    user_ctl_chk: assert property (@(posedge clk) disable iff (rst)
        (psw_q.mode == M_USR && !req_reset && !req_dabort && !req_pabort
         && !req_undef && !req_svc && !req_int && !req_fint)
        |=> (psw_out[7:0] == $past(psw_out[7:0])));
    // R10
    mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
        mode_valid(psw_q.mode));
    // R6
    ret_load_chk: assert property (@(posedge clk) disable iff (rst)
        ret_go |=> pc_load);

endmodule

// File: tb/sim_psw_exc_ctrl.sv
`timescale 1ns/1ps
module sim_psw_exc_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_reset, req_undef, req_svc, req_pabort, req_dabort, req_int, req_fint;
    logic [31:0] cur_pc;
    logic        flag_we;
    logic [3:0]  flag_nzcv;
    logic        sw_we;
    logic [1:0]  sw_sel;
    logic [31:0] sw_data;
    logic        ret_req;
    logic [3:0]  ret_adj;
    logic        pc_load;
    logic [31:0] pc_vec;
    logic [4:0]  cur_mode;
    logic        half_isa, int_mask, fint_mask;
    logic [31:0] psw_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench model
    logic [31:0] m_psw;
    logic [31:0] m_link [5];
    logic [31:0] m_sav  [5];
    logic        m_load;
    logic [31:0] m_vec;

    always #2.5 clk = ~clk;

    psw_exc_ctrl u0 (
        .clk(clk), .rst(rst),
        .req_reset(req_reset), .req_undef(req_undef), .req_svc(req_svc),
        .req_pabort(req_pabort), .req_dabort(req_dabort),
        .req_int(req_int), .req_fint(req_fint),
        .cur_pc(cur_pc), .flag_we(flag_we), .flag_nzcv(flag_nzcv),
        .sw_we(sw_we), .sw_sel(sw_sel), .sw_data(sw_data),
        .ret_req(ret_req), .ret_adj(ret_adj),
        .pc_load(pc_load), .pc_vec(pc_vec), .cur_mode(cur_mode),
        .half_isa(half_isa), .int_mask(int_mask), .fint_mask(fint_mask),
        .psw_out(psw_out)
    );

    function automatic int bidx(input logic [4:0] m);
        case (m)
            5'h11: return 0;
            5'h12: return 1;
            5'h13: return 2;
            5'h17: return 3;
            5'h1B: return 4;
            default: return -1;
        endcase
    endfunction

    function automatic bit legal(input logic [4:0] m);
        return (m == 5'h10 || m == 5'h11 || m == 5'h12 || m == 5'h13 ||
                m == 5'h17 || m == 5'h1B || m == 5'h1F);
    endfunction

    task automatic model_reset();
        m_psw  = 32'h0000_00D3;
        m_load = 1'b0;
        for (int i = 0; i < 5; i++) begin
            m_link[i] = '0;
            m_sav[i]  = 32'h0000_00D3;
        end
    endtask

    task automatic model_step();
        int t;
        int b;
        logic [4:0] tm;
        t = -1;
        if (req_reset)                     t = 0;
        else if (req_dabort)               t = 4;
        else if (req_fint && !m_psw[6])    t = 7;
        else if (req_int && !m_psw[7])     t = 6;
        else if (req_pabort)               t = 3;
        else if (req_undef)                t = 1;
        else if (req_svc)                  t = 2;
        if (t >= 0) begin
            case (t)
                1: tm = 5'h1B;
                3, 4: tm = 5'h17;
                6: tm = 5'h12;
                7: tm = 5'h11;
                default: tm = 5'h13;
            endcase
            b = bidx(tm);
            m_link[b] = cur_pc;
            m_sav[b]  = m_psw;
            m_psw[4:0] = tm;
            m_psw[7] = 1'b1;
            if (t == 0 || t == 7) m_psw[6] = 1'b1;
            m_psw[5] = 1'b0;
            m_load = 1'b1;
            m_vec  = 32'(t * 4);
        end else if (ret_req && bidx(m_psw[4:0]) >= 0) begin
            b = bidx(m_psw[4:0]);
            m_psw  = m_sav[b];
            m_load = 1'b1;
            m_vec  = m_link[b] - {28'h0, ret_adj};
        end else begin
            m_load = 1'b0;
            if (sw_we) begin
                if (sw_sel[1]) m_psw[31:28] = sw_data[31:28];
                if (sw_sel[0] && m_psw[4:0] != 5'h10) begin
                    m_psw[7:5] = sw_data[7:5];
                    if (legal(sw_data[4:0])) m_psw[4:0] = sw_data[4:0];
                end
            end else if (flag_we) begin
                m_psw[31:28] = flag_nzcv;
            end
        end
    endtask

    task automatic compare(input string tag);
        bit ok;
        ok = (psw_out == m_psw) && (pc_load == m_load) &&
             (!m_load || pc_vec == m_vec) && (cur_mode == m_psw[4:0]) &&
             (half_isa == m_psw[5]) && (fint_mask == m_psw[6]) &&
             (int_mask == m_psw[7]);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: psw=%h load=%0d vec=%h expected psw=%h load=%0d vec=%h",
                     tag, psw_out, pc_load, pc_vec, m_psw, m_load, m_vec);
        end
    endtask

    task automatic idle();
        req_reset = 0; req_undef = 0; req_svc = 0; req_pabort = 0;
        req_dabort = 0; req_int = 0; req_fint = 0;
        cur_pc = '0; flag_we = 0; flag_nzcv = '0;
        sw_we = 0; sw_sel = '0; sw_data = '0; ret_req = 0; ret_adj = '0;
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_step();
        #1;
        compare(tag);
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d, input string tag);
        idle();
        sw_we = 1; sw_sel = s; sw_data = d;
        tick(tag);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            finish_run();
        end
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        model_reset();
        // R1: reset value
        compare("R1");
        n_chk++;
        if (psw_out != 32'h0000_00D3 || pc_load != 1'b0) begin
            n_bad++;
            $display("FAIL R1: psw=%h load=%0d expected psw=000000d3 load=0", psw_out, pc_load);
        end

        // R7: every flag pattern
        for (int f = 0; f < 16; f++) begin
            idle(); flag_we = 1; flag_nzcv = 4'(f);
            tick("R7");
        end

        // R8: all-ones write leaves reserved bits alone
        wr(2'b11, 32'hFFFF_FF1F, "R8");
        n_chk++;
        if (psw_out[27:8] != 20'h0) begin
            n_bad++;
            $display("FAIL R8: reserved=%h expected 00000", psw_out[27:8]);
        end

        // R10: illegal mode codes keep the mode
        for (int m = 0; m < 32; m++) begin
            wr(2'b01, {24'h0, 3'(m), 5'(m)}, "R10");
            wr(2'b01, 32'h0000_001F, "R10");
        end

        // R9: user mode cannot touch control bits
        wr(2'b01, 32'h0000_0010, "R9");
        wr(2'b01, 32'h0000_00D3, "R9");
        wr(2'b10, 32'hA000_0000, "R9");
        idle(); ret_req = 1; sw_we = 1; sw_sel = 2'b11; sw_data = 32'h5000_00FF;
        tick("R9/R6");
        idle(); flag_we = 1; flag_nzcv = 4'h3; ret_req = 1;
        tick("R11");

        // R6: enter and return
        idle(); req_svc = 1; cur_pc = 32'h0000_1234;
        tick("R3");
        idle(); ret_req = 1; ret_adj = 4'd4;
        tick("R6");
        n_chk++;
        if (pc_vec != 32'h0000_1230 || cur_mode != 5'h10) begin
            n_bad++;
            $display("FAIL R6: vec=%h mode=%h expected vec=00001230 mode=10", pc_vec, cur_mode);
        end

        // R2/R3/R4/R5: every request combination under every mask setting
        for (int mk = 0; mk < 4; mk++) begin
            for (int rq = 0; rq < 128; rq++) begin
                idle(); req_reset = 1;
                tick("R3");
                wr(2'b01, {24'h0, 1'(mk >> 1), 1'(mk), 1'b1, 5'h1F}, "R8");
                idle();
                req_reset  = rq[0]; req_undef = rq[1]; req_svc = rq[2];
                req_pabort = rq[3]; req_dabort = rq[4]; req_int = rq[5];
                req_fint   = rq[6];
                cur_pc = $urandom & 32'hFFFF_FFFC;
                tick("R2/R3/R4/R5");
                idle(); ret_req = 1; ret_adj = 4'($urandom);
                tick("R6");
            end
        end

        // R11: everything in one cycle
        idle(); req_undef = 1; ret_req = 1; sw_we = 1; sw_sel = 2'b11;
        sw_data = 32'h3000_001F; flag_we = 1; flag_nzcv = 4'hC; cur_pc = 32'h40;
        tick("R11");
        idle(); ret_req = 1; sw_we = 1; sw_sel = 2'b11; sw_data = 32'h3000_001F;
        tick("R11");

        // R11: random mixed traffic
        for (int k = 0; k < 3000; k++) begin
            idle();
            req_reset  = ($urandom % 64) == 0;
            req_undef  = ($urandom % 16) == 0;
            req_svc    = ($urandom % 16) == 0;
            req_pabort = ($urandom % 16) == 0;
            req_dabort = ($urandom % 16) == 0;
            req_int    = ($urandom % 8) == 0;
            req_fint   = ($urandom % 8) == 0;
            cur_pc     = $urandom;
            ret_req    = ($urandom % 8) == 0;
            ret_adj    = 4'($urandom);
            sw_we      = ($urandom % 4) == 0;
            sw_sel     = 2'($urandom);
            sw_data    = $urandom;
            flag_we    = ($urandom % 2) == 0;
            flag_nzcv  = 4'($urandom);
            tick("R11");
        end

        done = 1'b1;
        finish_run();
    end

endmodule